// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Inverted-Capture Self-Test

This block is a chain of boundary-scan cells placed between a device's functional signals and its core logic. Each cell holds a shift stage, clocked on the rising test-clock edge, and a shadow latch, loaded on the falling edge. In normal operation every functional signal passes straight through. The chain can still sample those signals into the shift stages and shift them out serially. A pattern shifted in from the serial input can be moved into the shadow latches ahead of time. When test mode is raised, the outputs are then driven from those latches.

A self-test capture loads each shift stage with the inverse of its own shadow latch. Shifting the result out shows whether the shadow latches hold what was last written, and whether the shift path carries every bit intact. Sequencing of the strobes comes from outside (a test access port controller). This block only obeys them. The chain length must be at least 2.

Top module: `bscan_chain`

## Requirements
- R1: An active-low asynchronous reset clears every shift stage and every shadow latch to 0 and forces pass-through (`funcOut == funcIn`) while it is held, whatever `testMode` is.
- R2: Outside test mode `funcOut` equals `funcIn` bit for bit, in every cycle.
- R3: A rising test-clock edge with `captureEn` high and `selfTest` low loads `funcIn[i]` into shift stage i for every cell.
- R4: A rising edge with `shiftEn` high and `captureEn` low moves stage i+1 into stage i and `tdi` into stage N-1. `tdo` always shows stage 0, so cell 0 leaves the chain first.
- R5: When `captureEn` and `shiftEn` are both high, the capture takes place and no shift occurs.
- R6: A falling edge with `updateEn` high copies every shift stage into its shadow latch. When `updateEn` is low the shadow latches keep their value, however much shifting takes place.
- R7: In test mode (`testMode` high, reset released) `funcOut` equals the shadow latches. It does not change while test mode is held and no update occurs, even when `funcIn` changes.
- R8: A rising edge with `captureEn` and `selfTest` both high loads the inverse of shadow latch i into shift stage i.
- R9: A rising edge with neither `captureEn` nor `shiftEn` high leaves the shift stages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shift stages on rising edge, shadow latches on falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in, enters cell N-1 |
| tdo | output | 1 | Serial data out, shows cell 0 |
| captureEn | input | 1 | Capture strobe (Capture-DR) |
| shiftEn | input | 1 | Shift strobe (Shift-DR) |
| updateEn | input | 1 | Update strobe (Update-DR), acts on the falling edge |
| testMode | input | 1 | Drive outputs from the shadow latches |
| selfTest | input | 1 | Make a capture load inverted shadow values |
| funcIn | input | CELLS | Functional values arriving at the cells |
| funcOut | output | CELLS | Functional values leaving the cells |

## Verification
On every rising edge the bound checker asserts the following: the pass-through outside test mode, the sample and inverted captures, the shift step with capture taking priority over it, shadow-latch hold without an update, and output stability in test mode. The bench's scenarios cover the remaining behaviour. They show that a preloaded pattern reaches the outputs only when test mode is raised. They show that a self-test capture, once shifted out, returns the exact complement of that pattern. They also show that a reset taken in the middle of test mode returns the outputs to pass-through at once.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic cap;     // capture this rising edge
    logic capInv;  // capture selects inverted shadow value
    logic shift;   // shift this rising edge
    logic upd;     // update shadow on falling edge
    logic drive;   // outputs come from shadow latches
  } bsStrobe_t;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl (
  input  logic                 rstN,
  input  logic                 captureEn,
  input  logic                 shiftEn,
  input  logic                 updateEn,
  input  logic                 testMode,
  input  logic                 selfTest,
  output bscan_pkg::bsStrobe_t strobe
);
  always_comb begin
    strobe.cap    = captureEn;
    strobe.capInv = selfTest;
    strobe.shift  = shiftEn & ~captureEn;  // capture wins
    strobe.upd    = updateEn;
    strobe.drive  = testMode & rstN;       // reset forces normal mode
  end
endmodule

// File: rtl/bscan_dp.sv
module bscan_dp #(
  parameter int CELLS = 8
) (
  input  logic                 tck,
  input  logic                 rstN,
  input  logic                 tdi,
  input  bscan_pkg::bsStrobe_t strobe,
  input  logic [CELLS-1:0]     funcIn,
  output logic [CELLS-1:0]     funcOut,
  output logic [CELLS-1:0]     shiftQ,
  output logic [CELLS-1:0]     shadowQ,
  output logic                 tdo
);
  localparam int LAST = CELLS - 1;

  for (genvar i = 0; i < CELLS; i++) begin : gCell
    logic serialIn;
    logic capVal;
    if (i == LAST) begin : gEnd
      assign serialIn = tdi;
    end else begin : gMid
      assign serialIn = shiftQ[i+1];
    end
    assign capVal = strobe.capInv ? ~shadowQ[i] : funcIn[i];

    always_ff @(posedge tck or negedge rstN) begin
      if (!rstN)             shiftQ[i] <= 1'b0;
      else if (strobe.cap)   shiftQ[i] <= capVal;
      else if (strobe.shift) shiftQ[i] <= serialIn;
    end

    always_ff @(negedge tck or negedge rstN) begin
      if (!rstN)           shadowQ[i] <= 1'b0;
      else if (strobe.upd) shadowQ[i] <= shiftQ[i];
    end

    assign funcOut[i] = strobe.drive ? shadowQ[i] : funcIn[i];
  end

  assign tdo = shiftQ[0];
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int CELLS = 8
) (
  input  logic             tck,
  input  logic             rstN,
  input  logic             tdi,
  output logic             tdo,
  input  logic             captureEn,
  input  logic             shiftEn,
  input  logic             updateEn,
  input  logic             testMode,
  input  logic             selfTest,
  input  logic [CELLS-1:0] funcIn,
  output logic [CELLS-1:0] funcOut
);
  bscan_pkg::bsStrobe_t strobe;
  logic [CELLS-1:0] shiftQ;
  logic [CELLS-1:0] shadowQ;

  bscan_ctrl uCtrl (
    .rstN(rstN), .captureEn(captureEn), .shiftEn(shiftEn),
    .updateEn(updateEn), .testMode(testMode), .selfTest(selfTest),
    .strobe(strobe)
  );

  bscan_dp #(.CELLS(CELLS)) uDp (
    .tck(tck), .rstN(rstN), .tdi(tdi), .strobe(strobe),
    .funcIn(funcIn), .funcOut(funcOut), .shiftQ(shiftQ),
    .shadowQ(shadowQ), .tdo(tdo)
  );
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int CELLS = 8
) (
  input logic             tck,
  input logic             rstN,
  input logic             tdi,
  input logic             tdo,
  input logic             captureEn,
  input logic             shiftEn,
  input logic             updateEn,
  input logic             testMode,
  input logic             selfTest,
  input logic [CELLS-1:0] funcIn,
  input logic [CELLS-1:0] funcOut,
  input logic [CELLS-1:0] shiftQ,
  input logic [CELLS-1:0] shadowQ
);
  a_r2_passthrough: assert property (@(posedge tck) disable iff (!rstN)
    !testMode |-> funcOut == funcIn);

  a_r3_sample: assert property (@(posedge tck) disable iff (!rstN)
    captureEn && !selfTest |=> shiftQ == $past(funcIn));

  // R4 and R5: a shift step only without capture; tdo shows cell 0
  a_r4_shift_step: assert property (@(posedge tck) disable iff (!rstN)
    shiftEn && !captureEn |=> shiftQ == {$past(tdi), $past(shiftQ[CELLS-1:1])});

  a_r4_tdo_end: assert property (@(posedge tck) disable iff (!rstN)
    tdo == shiftQ[0]);

  a_r6_shadow_hold: assert property (@(posedge tck) disable iff (!rstN)
    !updateEn |-> $stable(shadowQ));

  a_r7_drive_hold: assert property (@(posedge tck) disable iff (!rstN)
    testMode && $past(testMode) && !updateEn |-> $stable(funcOut));

  a_r7_drive_shadow: assert property (@(posedge tck) disable iff (!rstN)
    testMode |-> funcOut == shadowQ);

  a_r8_inverse: assert property (@(posedge tck) disable iff (!rstN)
    captureEn && selfTest |=> shiftQ == ~$past(shadowQ));

  a_r9_idle: assert property (@(posedge tck) disable iff (!rstN)
    !captureEn && !shiftEn |=> $stable(shiftQ));
endmodule

bind bscan_chain bscan_chain_chk #(.CELLS(CELLS)) uChk (
  .tck(tck), .rstN(rstN), .tdi(tdi), .tdo(tdo), .captureEn(captureEn),
  .shiftEn(shiftEn), .updateEn(updateEn), .testMode(testMode),
  .selfTest(selfTest), .funcIn(funcIn), .funcOut(funcOut),
  .shiftQ(shiftQ), .shadowQ(shadowQ)
);

// File: tb/sim_bscan_chain.sv
`timescale 1ns/1ps
module sim_bscan_chain;
  localparam int N = 8;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic tdi = 1'b0, captureEn = 1'b0, shiftEn = 1'b0, updateEn = 1'b0;
  logic testMode = 1'b0, selfTest = 1'b0;
  logic [N-1:0] funcIn = '0;
  logic tdo;
  logic [N-1:0] funcOut;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #5 tck = ~tck;

  bscan_chain #(.CELLS(N)) u0 (
    .tck(tck), .rstN(rstN), .tdi(tdi), .tdo(tdo), .captureEn(captureEn),
    .shiftEn(shiftEn), .updateEn(updateEn), .testMode(testMode),
    .selfTest(selfTest), .funcIn(funcIn), .funcOut(funcOut)
  );

  // behavioural reference: queue front is the TDO end
  bit mQ[$];
  bit mShadow[N];

  initial for (int i = 0; i < N; i++) begin mQ.push_back(0); mShadow[i] = 0; end

  always @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin mQ[i] = 0; mShadow[i] = 0; end
    end else if (captureEn) begin
      for (int i = 0; i < N; i++) mQ[i] = selfTest ? !mShadow[i] : funcIn[i];
    end else if (shiftEn) begin
      void'(mQ.pop_front());
      mQ.push_back(tdi);
    end
  end

  always @(negedge tck)
    if (rstN && updateEn) for (int i = 0; i < N; i++) mShadow[i] = mQ[i];

  function automatic logic [N-1:0] expOut();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (rstN && testMode) ? mShadow[i] : funcIn[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, after the falling-edge update and before the next rising edge
  always @(negedge tck) begin
    #4;
    if (!done) begin
      check("R4 tdo", {{(N-1){1'b0}}, tdo}, {{(N-1){1'b0}}, mQ[0]});
      check((rstN && testMode) ? "R7 funcOut" : "R2 funcOut", funcOut, expOut());
    end
  end

  task automatic cyc();
    @(posedge tck); #1;
  endtask

  task automatic shiftIn(input logic [N-1:0] pat);
    shiftEn = 1;
    for (int i = 0; i < N; i++) begin tdi = pat[i]; cyc(); end
    shiftEn = 0; tdi = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  logic [N-1:0] pat;
  logic [N-1:0] got;

  initial begin
    funcIn = 8'h5A;
    testMode = 1;
    repeat (2) cyc();
    // R1: reset state, pass-through even with testMode high
    check("R1 reset funcOut", funcOut, 8'h5A);
    check("R1 reset tdo", {7'b0, tdo}, 8'h00);
    testMode = 0;
    rstN = 1;
    // R2: normal pass-through across varied inputs
    for (int k = 0; k < 6; k++) begin funcIn = 8'h11 * k[7:0] ^ 8'hC3; cyc(); end
    // R3: sample capture, then shift out (R4 ordering)
    funcIn = 8'hB6; captureEn = 1; cyc(); captureEn = 0;
    funcIn = 8'h00;
    shiftEn = 1;
    for (int i = 0; i < N; i++) begin #7; got[i] = tdo; @(posedge tck); #1; end
    shiftEn = 0;
    check("R3 sampled", got, 8'hB6);
    // R9: idle cycles hold stages
    repeat (3) cyc();
    // R6: preload a pattern, then update
    pat = 8'h9C;
    shiftIn(pat);
    updateEn = 1; cyc(); updateEn = 0;
    // R6: shifting without update keeps shadow; R7: drive from shadow and hold
    testMode = 1;
    cyc(); #7;
    check("R7 driven", funcOut, pat);
    @(posedge tck); #1;
    shiftIn(8'hFF);
    funcIn = 8'h3C; cyc();
    #7;
    check("R6 shadow hold", funcOut, pat);
    @(posedge tck); #1;
    // R8: self-test capture returns inverse of shadow
    selfTest = 1; captureEn = 1; cyc(); captureEn = 0; selfTest = 0;
    shiftEn = 1;
    for (int i = 0; i < N; i++) begin #7; got[i] = tdo; @(posedge tck); #1; end
    shiftEn = 0;
    check("R8 inverse", got, ~pat);
    // R5: capture and shift together, capture wins
    funcIn = 8'hE1; captureEn = 1; shiftEn = 1; tdi = 1; cyc();
    captureEn = 0; shiftEn = 0; tdi = 0; testMode = 0;
    cyc();
    // R1: reset during test mode
    testMode = 1; cyc();
    rstN = 0; #1;
    check("R1 mid reset", funcOut, funcIn);
    cyc(); rstN = 1; testMode = 0;
    repeat (3) cyc();
    finishRun();
  end
endmodule